// File: doc/BRIEF.md
# XOR-Indexed Bit Permutation Unit

This execution unit rearranges the bits of a source operand with an XOR-indexed permutation. Every result bit j is copied from source bit `j XOR c`, where `c` is a small control value. Each control bit swaps adjacent blocks of one size: single bits, pairs, nibbles, bytes, halfwords or words. Any combination of those swaps therefore comes from one operation. With all control bits set, the operation is a full bit reversal.

The control value comes from one of two places. In the register form it is the low bits of a second register operand. In the immediate form it is a decoded instruction immediate. A word mode permutes only the low half of the operand and clears the upper half. When the record bit is set, the unit also produces a 4-bit condition field derived from the result, together with a write enable for it. The result and the condition outputs pass through an optional output register, so the unit fits into a single-cycle execution stage.

Top module: `grev_unit`

## Requirements
- R1: In full mode (`word_i`=0), result bit j equals source bit (j XOR c) for every j in 0..XLEN-1, where c is the log2(XLEN)-bit control value.
- R2: With `imm_sel_i`=0, c is taken from `rb_i[log2(XLEN)-1:0]`. All higher bits of `rb_i` have no effect on any output.
- R3: With `imm_sel_i`=1, c is taken from `imm_i`. `rb_i` has no effect on any output.
- R4: In word mode (`word_i`=1), result bit j equals source bit (j XOR c') for j in 0..XLEN/2-1, where c' is the selected control with its top bit forced to 0. The top bit of the control and the upper source half have no effect on the low half of the result.
- R5: In word mode, result bits XLEN-1..XLEN/2 are zero.
- R6: A control value of 0 passes the selected width through unchanged. An all-ones control reverses its bit order.
- R7: `cr_we_o` equals the record bit `rc_i` of the same operation.
- R8: When the record bit is set, `cr_o` is {neg, pos, zero, so}. Bit 3 is set when the result read as a signed number is below zero. Bit 2 is set when it is above zero. Bit 1 is set when it equals zero. Bit 0 copies `so_i`. Exactly one of bits 3..1 is set.
- R9: With OUT_REG=1, outputs appear one clock after the inputs. A synchronous active-high `rst` clears the result, `cr_o` and `cr_we_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | XLEN | Operand to be permuted |
| rb_i | input | XLEN | Second register operand (control source in register form) |
| imm_i | input | log2(XLEN) | Decoded control immediate |
| word_i | input | 1 | 1 = word mode on the low half |
| imm_sel_i | input | 1 | 1 = control from `imm_i`, 0 = from `rb_i` |
| rc_i | input | 1 | Record bit: request a condition-field write |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| res_o | output | XLEN | Permuted result |
| cr_o | output | 4 | Condition field {neg, pos, zero, so} |
| cr_we_o | output | 1 | Condition-field write enable |

## Verification
The bench builds the unit with its defaults, XLEN=64 and OUT_REG=1. This lets it sweep every one of the 64 full-width control values and every one of the 32 word-mode control values, in both the register form and the immediate form. Each sweep runs over several source patterns, and the bench fills the control bits that must be ignored with junk. It also targets the extremes: pass-through, full reversal, a source whose ones lie only in the upper half in word mode, and results that are negative, positive or zero. This covers every condition flag.

// File: rtl/grev_pkg.sv
package grev_pkg;

    // Condition field layout, most significant first
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic so;
    } cond_field_t;

    // Operation flavour as seen by the unit
    typedef enum logic [1:0] {
        OPK_FULL_REG = 2'b00,
        OPK_FULL_IMM = 2'b01,
        OPK_WORD_REG = 2'b10,
        OPK_WORD_IMM = 2'b11
    } op_kind_t;

    function automatic op_kind_t make_kind(input logic word, input logic isel);
        return op_kind_t'({word, isel});
    endfunction

endpackage

// File: rtl/grev_ctrl_sel.sv
module grev_ctrl_sel
    import grev_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int CW  = $clog2(XLEN)
) (
    input  logic [CW-1:0] rb_ctl_i,
    input  logic [CW-1:0] imm_i,
    input  op_kind_t      kind_i,
    output logic [CW-1:0] ctl_o
);
    always_comb begin
        unique case (kind_i)
            OPK_FULL_REG: ctl_o = rb_ctl_i;
            OPK_FULL_IMM: ctl_o = imm_i;
            OPK_WORD_REG: ctl_o = {1'b0, rb_ctl_i[CW-2:0]};
            OPK_WORD_IMM: ctl_o = {1'b0, imm_i[CW-2:0]};
            default:      ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/grev_swap_net.sv
module grev_swap_net #(
    parameter int XLEN = 64,
    localparam int CW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [CW-1:0]   ctl,
    output logic [XLEN-1:0] dout
);
    logic [XLEN-1:0] lvl [0:CW];

    assign lvl[0] = din;

    // Stage k exchanges neighbouring blocks of 2**k bits
    for (genvar k = 0; k < CW; k++) begin : g_stage
        for (genvar j = 0; j < XLEN; j++) begin : g_bit
            assign lvl[k+1][j] = ctl[k] ? lvl[k][j ^ (1 << k)] : lvl[k][j];
        end
    end

    assign dout = lvl[CW];
endmodule

// File: rtl/grev_cond_gen.sv
module grev_cond_gen
    import grev_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val_i,
    input  logic            so_i,
    output cond_field_t     cf_o
);
    always_comb begin
        cf_o.neg  = val_i[XLEN-1];
        cf_o.zero = (val_i == '0);
        cf_o.pos  = !val_i[XLEN-1] && (val_i != '0);
        cf_o.so   = so_i;
    end
endmodule

// File: rtl/grev_unit.sv
module grev_unit
    import grev_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int CW     = $clog2(XLEN),
    localparam int HALF   = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [CW-1:0]   imm_i,
    input  logic            word_i,
    input  logic            imm_sel_i,
    input  logic            rc_i,
    input  logic            so_i,
    output logic [XLEN-1:0] res_o,
    output logic [3:0]      cr_o,
    output logic            cr_we_o
);
    op_kind_t        kind;
    logic [CW-1:0]   ctl;
    logic [XLEN-1:0] perm;
    logic [XLEN-1:0] res_c;
    cond_field_t     cf_c;

    assign kind = make_kind(word_i, imm_sel_i);

    grev_ctrl_sel #(.XLEN(XLEN)) u_ctl (
        .rb_ctl_i (rb_i[CW-1:0]),
        .imm_i    (imm_i),
        .kind_i   (kind),
        .ctl_o    (ctl)
    );

    grev_swap_net #(.XLEN(XLEN)) u_net (
        .din  (src_i),
        .ctl  (ctl),
        .dout (perm)
    );

    assign res_c = word_i ? {{HALF{1'b0}}, perm[HALF-1:0]} : perm;

    grev_cond_gen #(.XLEN(XLEN)) u_cond (
        .val_i (res_c),
        .so_i  (so_i),
        .cf_o  (cf_c)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_o   <= '0;
                cr_o    <= '0;
                cr_we_o <= 1'b0;
            end else begin
                res_o   <= res_c;
                cr_o    <= cf_c;
                cr_we_o <= rc_i;
            end
        end

        AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
            word_i |=> (res_o[XLEN-1:HALF] == '0)); // R5
        AST_CR_WE_SET: assert property (@(posedge clk) disable iff (rst)
            rc_i |=> cr_we_o); // R7
        AST_CR_WE_CLEAR: assert property (@(posedge clk) disable iff (rst)
            !rc_i |=> !cr_we_o); // R7
        AST_CTRL_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
            (!word_i && !imm_sel_i && rb_i[CW-1:0] == '0) |=> (res_o == $past(src_i))); // R6
        AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
            cr_we_o |-> ($countones(cr_o[3:1]) == 1)); // R8
        AST_SO_COPY: assert property (@(posedge clk) disable iff (rst)
            rc_i |=> (cr_o[0] == $past(so_i))); // R8
    end else begin : g_comb
        assign res_o   = res_c;
        assign cr_o    = cf_c;
        assign cr_we_o = rc_i;
    end
endmodule

// File: tb/sim_grev_unit.sv
`timescale 1ns/1ps
module sim_grev_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic [XLEN-1:0] src_i, rb_i;
    logic [5:0]      imm_i;
    logic            word_i, imm_sel_i, rc_i, so_i;
    logic [XLEN-1:0] res_o;
    logic [3:0]      cr_o;
    logic            cr_we_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    grev_unit u0 (
        .clk(clk), .rst(rst), .src_i(src_i), .rb_i(rb_i), .imm_i(imm_i),
        .word_i(word_i), .imm_sel_i(imm_sel_i), .rc_i(rc_i), .so_i(so_i),
        .res_o(res_o), .cr_o(cr_o), .cr_we_o(cr_we_o)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x ^= x << 13;
        x ^= x >> 7;
        x ^= x << 17;
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Applies one operation and checks it against a bit-by-bit model
    task automatic run_op(input logic [63:0] s, input logic [63:0] rb,
                          input logic [5:0] imm, input bit word, input bit isel,
                          input bit rc, input bit so, input string req);
        logic [5:0]  c;
        logic [63:0] exp;
        logic [3:0]  exp_cr;
        @(negedge clk);
        src_i = s; rb_i = rb; imm_i = imm; word_i = word;
        imm_sel_i = isel; rc_i = rc; so_i = so;
        c = isel ? imm : rb[5:0];
        exp = '0;
        if (word) begin
            c[5] = 1'b0;
            for (int i = 0; i < 32; i++) exp[i] = s[i ^ int'(c)];
        end else begin
            for (int i = 0; i < 64; i++) exp[i] = s[i ^ int'(c)];
        end
        if ($signed(exp) < 0)      exp_cr = {3'b100, so};
        else if (exp == '0)        exp_cr = {3'b001, so};
        else                       exp_cr = {3'b010, so};
        @(negedge clk);
        check(res_o === exp, req, res_o, exp);
        check(cr_we_o === rc, "R7", 64'(cr_we_o), 64'(rc));
        if (rc) check(cr_o === exp_cr, "R8", 64'(cr_o), 64'(exp_cr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] srcs [4];
        rst = 1'b1;
        src_i = '1; rb_i = '1; imm_i = '1; word_i = 1'b0;
        imm_sel_i = 1'b0; rc_i = 1'b1; so_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_o === '0, "R9 reset result", res_o, 64'h0);
        check(cr_o === 4'h0 && cr_we_o === 1'b0, "R9 reset cond", {cr_o, cr_we_o}, 64'h0);
        rst = 1'b0;

        srcs[0] = 64'h0123_4567_89AB_CDEF;
        srcs[1] = 64'h8000_0000_0000_0001;
        for (int k = 2; k < 4; k++) begin
            rng = next_rand(rng);
            srcs[k] = rng;
        end

        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 64; c++) begin
                rng = next_rand(rng);
                // R1 R2: control from low rb bits, junk above
                run_op(srcs[k], {rng[63:6], 6'(c)}, rng[5:0], 1'b0, 1'b0,
                       rng[7], rng[8], "R1 R2 full reg");
                rng = next_rand(rng);
                // R3: rb is junk, control from immediate
                run_op(srcs[k], rng, 6'(c), 1'b0, 1'b1, 1'b1, rng[9], "R3 full imm");
            end
            for (int c = 0; c < 32; c++) begin
                rng = next_rand(rng);
                // R4 R5: control bit 5 set as junk, must be ignored
                run_op(srcs[k], {rng[63:6], 1'b1, 5'(c)}, rng[5:0], 1'b1, 1'b0,
                       1'b1, rng[10], "R4 R5 word reg");
                rng = next_rand(rng);
                run_op(srcs[k], rng, {1'b1, 5'(c)}, 1'b1, 1'b1, rng[3], 1'b0,
                       "R4 R5 word imm");
            end
        end

        // R6: pass-through and full reversal
        run_op(64'hDEAD_BEEF_0BAD_F00D, 64'hFFFF_FFFF_FFFF_FFC0, 6'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 pass");
        run_op(64'h0000_0000_0000_0001, 64'h0, 6'h3F, 1'b0, 1'b1, 1'b1, 1'b0, "R6 reverse full");
        run_op(64'h0000_0000_0000_0001, 64'h1F, 6'h0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 reverse word");
        // R5 R8: upper-half ones in word mode with control 6 gives zero
        run_op(64'hFFFF_FFFF_0000_0000, 64'h6, 6'h0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 upper ones word");
        // R8: positive and negative results
        run_op(64'h0000_0000_0000_0002, 64'h0, 6'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R8 positive");
        run_op(64'h0000_0000_0000_0004, 64'h3D, 6'h0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 negative");

        // R9: reset clears outputs after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(res_o === '0 && cr_we_o === 1'b0, "R9 re-reset", res_o, 64'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule